// File: doc/BRIEF.md
# Interleaved Bank-Group Address Mapper

This block sits in front of a result buffer built from `N_BANKS` independent single-port banks, each holding rows of `ROW_W` bits. A width code selects how many adjacent banks work together as one group (one, two or four), so that a single access moves one, two or four bank rows for single, mixed or half precision work. Every incoming data block is placed by a running block counter: consecutive blocks go to the same row of consecutive groups, and after the last group the placement wraps to group 0 at the next row. A streaming reader and a streaming writer that trail each other by a block or more therefore tend to hit different groups, and so different banks.

The write side turns each valid beat into per-bank write enables, a shared in-group row address and per-bank data slices. The read side runs an identical, separate counter, so blocks come back in the order they were written; it issues per-bank read enables and a row, then collects the returned bank rows of the addressed group into one wide word. A tile-start pulse rewinds both counters. Placement needs no divider: with power-of-two widths the group is the low bits of the counter and the row is the remaining bits.

Top module: `bank_group_mapper`

## Requirements
- R1: While rst_ni is low and before the first beat, wr_en_o and rd_en_o are all zero and rd_data_valid_o is low.
- R2: width_sel_i code 0, 1 and 2 give X = 1, 2 and 4 banks per group and N_BANKS/X groups; group g is banks g*X to g*X+X-1, and one accepted write beat raises exactly those X bits of wr_en_o, with wr_grp_o = g.
- R3: On a write beat, bank b receives slice (b mod X) of wr_data_i, where slice s is bits [s*ROW_W +: ROW_W]; bank b's data appears at wr_data_o[b*ROW_W +: ROW_W].
- R4: Each accepted write beat places its block in the next group at the same row; after the last group the next block goes to group 0 at row + 1.
- R5: A cycle without an accepted beat raises no enable and leaves the placement position unchanged.
- R6: tile_start_i rewinds both the write and the read position to group 0, row 0; a beat in the same cycle as tile_start_i lands at group 0, row 0 and the next beat at group 1.
- R7: Width code 3, or any code that leaves fewer than two groups, raises cfg_err_o in the same cycle; beats during that cycle raise no enable and do not move either position.
- R8: The row address wraps to 0 after row 2^ROW_AW - 1 in the last group.
- R9: Read beats use the same mapping as writes with their own position: rd_en_o and rd_row_o follow the read position, and write beats do not move it nor read beats the write position.
- R10: One cycle after rd_en_o is raised, rd_data_valid_o is high and rd_data_o holds, in slice j for j < X, bank (g*X + j)'s row from rd_bank_data_i, with all slices j >= X zero.
- R11: Enables, row, group and data outputs are registered: they reflect a beat one clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tile_start_i | input | 1 | Rewinds both placement positions |
| width_sel_i | input | 2 | Group width code: 0 one bank, 1 two, 2 four, 3 reserved |
| wr_valid_i | input | 1 | One data block to write this cycle |
| wr_data_i | input | N_BANKS*ROW_W | Incoming block, low X*ROW_W bits used |
| rd_valid_i | input | 1 | Read the next block this cycle |
| rd_bank_data_i | input | N_BANKS*ROW_W | Row returned by each bank, bank b at [b*ROW_W +: ROW_W] |
| wr_en_o | output | N_BANKS | Per-bank write enable |
| wr_row_o | output | ROW_AW | Row address shared by the written group |
| wr_grp_o | output | log2(N_BANKS) | Group index of the write |
| wr_data_o | output | N_BANKS*ROW_W | Per-bank write data slices |
| rd_en_o | output | N_BANKS | Per-bank read enable |
| rd_row_o | output | ROW_AW | Row address shared by the read group |
| rd_grp_o | output | log2(N_BANKS) | Group index of the read |
| rd_data_o | output | N_BANKS*ROW_W | Collected group data, low X slices valid |
| rd_data_valid_o | output | 1 | rd_data_o holds a returned block |
| cfg_err_o | output | 1 | Width code is reserved or gives fewer than two groups |

## Verification
The two functions that can meet in one cycle are the tile-start rewind and a placement step, on the write and the read side at once. The bench raises tile_start_i together with a write beat and a read beat and expects both to land at group 0, row 0, with the next beats at group 1; a pulse without a beat must also rewind so the following beat starts at the origin. A second overlap, a read beat and a write beat in the same cycle, is judged by checking that each side's next placement ignores the other side's traffic.

// File: rtl/bgm_pkg.sv
package bgm_pkg;
  typedef enum logic [1:0] {
    WSEL_X1   = 2'd0,
    WSEL_X2   = 2'd1,
    WSEL_X4   = 2'd2,
    WSEL_RSVD = 2'd3
  } wsel_e;
endpackage

// File: rtl/bgm_cfg_decode.sv
module bgm_cfg_decode
  import bgm_pkg::*;
#(
  parameter int N_BANKS = 8
) (
  input  logic [1:0] wsel_i,
  output logic [1:0] log2x_o,
  output logic       err_o
);
  localparam int LOG_N = $clog2(N_BANKS);

  wsel_e wsel;
  assign wsel = wsel_e'(wsel_i);

  always_comb begin
    log2x_o = 2'd0;
    err_o   = 1'b0;
    case (wsel)
      WSEL_X1: log2x_o = 2'd0;
      WSEL_X2: log2x_o = 2'd1;
      WSEL_X4: log2x_o = 2'd2;
      default: err_o   = 1'b1;
    endcase
    // need at least two groups
    if (int'(log2x_o) >= LOG_N) err_o = 1'b1;
  end
endmodule

// File: rtl/bgm_walker.sv
module bgm_walker #(
  parameter int N_BANKS = 8,
  parameter int ROW_AW  = 6,
  localparam int LOG_N  = $clog2(N_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [1:0]        log2x_i,
  output logic [LOG_N-1:0]  grp_o,
  output logic [ROW_AW-1:0] row_o
);
  localparam int CNT_W = ROW_AW + LOG_N;

  logic [CNT_W-1:0] cnt_q, cur;
  logic [LOG_N:0]   gshift;
  logic [LOG_N-1:0] gmask;

  always_comb begin
    cur    = clr_i ? '0 : cnt_q;
    gshift = (LOG_N+1)'(LOG_N - int'(log2x_i));
    gmask  = LOG_N'((32'd1 << gshift) - 32'd1);
    grp_o  = cur[LOG_N-1:0] & gmask;
    row_o  = ROW_AW'(cur >> gshift);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cur + CNT_W'(adv_i);
  end

  // R5
  hold_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> (cnt_q == $past(cnt_q)));

  // R6
  clr_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !adv_i) |=> (cnt_q == '0));
endmodule

// File: rtl/bgm_en_decode.sv
module bgm_en_decode #(
  parameter int N_BANKS = 8,
  localparam int LOG_N  = $clog2(N_BANKS)
) (
  input  logic               valid_i,
  input  logic [LOG_N-1:0]   grp_i,
  input  logic [1:0]         log2x_i,
  output logic [N_BANKS-1:0] en_o
);
  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign en_o[b] = valid_i && ((LOG_N'(b) >> log2x_i) == grp_i);
  end
endmodule

// File: rtl/bgm_wr_route.sv
module bgm_wr_route #(
  parameter int N_BANKS = 8,
  parameter int ROW_W   = 1024
) (
  input  logic [N_BANKS*ROW_W-1:0] data_i,
  input  logic [1:0]               log2x_i,
  output logic [N_BANKS*ROW_W-1:0] bank_o
);
  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam int S2 = b % 2;
    localparam int S4 = b % 4;
    always_comb begin
      case (log2x_i)
        2'd0:    bank_o[b*ROW_W +: ROW_W] = data_i[0 +: ROW_W];
        2'd1:    bank_o[b*ROW_W +: ROW_W] = data_i[S2*ROW_W +: ROW_W];
        default: bank_o[b*ROW_W +: ROW_W] = data_i[S4*ROW_W +: ROW_W];
      endcase
    end
  end
endmodule

// File: rtl/bgm_rd_gather.sv
module bgm_rd_gather #(
  parameter int N_BANKS = 8,
  parameter int ROW_W   = 1024,
  localparam int LOG_N  = $clog2(N_BANKS)
) (
  input  logic [N_BANKS*ROW_W-1:0] bank_i,
  input  logic [LOG_N-1:0]         grp_i,
  input  logic [1:0]               log2x_i,
  output logic [N_BANKS*ROW_W-1:0] data_o
);
  for (genvar j = 0; j < N_BANKS; j++) begin : g_slice
    int idx;
    always_comb begin
      idx = (int'(grp_i) << log2x_i) + j;
      if ((j < (1 << log2x_i)) && (idx < N_BANKS))
        data_o[j*ROW_W +: ROW_W] = bank_i[idx*ROW_W +: ROW_W];
      else
        data_o[j*ROW_W +: ROW_W] = '0;
    end
  end
endmodule

// File: rtl/bank_group_mapper.sv
module bank_group_mapper
  import bgm_pkg::*;
#(
  parameter int N_BANKS = 8,
  parameter int ROW_W   = 1024,
  parameter int ROW_AW  = 6,
  localparam int LOG_N  = $clog2(N_BANKS),
  localparam int WORD_W = N_BANKS * ROW_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tile_start_i,
  input  logic [1:0]         width_sel_i,
  input  logic               wr_valid_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic               rd_valid_i,
  input  logic [WORD_W-1:0]  rd_bank_data_i,
  output logic [N_BANKS-1:0] wr_en_o,
  output logic [ROW_AW-1:0]  wr_row_o,
  output logic [LOG_N-1:0]   wr_grp_o,
  output logic [WORD_W-1:0]  wr_data_o,
  output logic [N_BANKS-1:0] rd_en_o,
  output logic [ROW_AW-1:0]  rd_row_o,
  output logic [LOG_N-1:0]   rd_grp_o,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               rd_data_valid_o,
  output logic               cfg_err_o
);
  logic [1:0]         log2x;
  logic               cfg_err;
  logic               wr_beat, rd_beat;
  logic [LOG_N-1:0]   wr_grp_d, rd_grp_d;
  logic [ROW_AW-1:0]  wr_row_d, rd_row_d;
  logic [N_BANKS-1:0] wr_en_d, rd_en_d;
  logic [WORD_W-1:0]  wr_data_d;

  logic [N_BANKS-1:0] wr_en_q, rd_en_q;
  logic [ROW_AW-1:0]  wr_row_q, rd_row_q;
  logic [LOG_N-1:0]   wr_grp_q, rd_grp_q, sel_grp_q;
  logic [WORD_W-1:0]  wr_data_q;
  logic [1:0]         rd_lx_q, sel_lx_q;
  logic               rd_dv_q;

  bgm_cfg_decode #(.N_BANKS(N_BANKS)) u_cfg (
    .wsel_i (width_sel_i),
    .log2x_o(log2x),
    .err_o  (cfg_err)
  );

  assign wr_beat = wr_valid_i && !cfg_err;
  assign rd_beat = rd_valid_i && !cfg_err;

  bgm_walker #(.N_BANKS(N_BANKS), .ROW_AW(ROW_AW)) u_wr_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tile_start_i),
    .adv_i  (wr_beat),
    .log2x_i(log2x),
    .grp_o  (wr_grp_d),
    .row_o  (wr_row_d)
  );

  bgm_walker #(.N_BANKS(N_BANKS), .ROW_AW(ROW_AW)) u_rd_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tile_start_i),
    .adv_i  (rd_beat),
    .log2x_i(log2x),
    .grp_o  (rd_grp_d),
    .row_o  (rd_row_d)
  );

  bgm_en_decode #(.N_BANKS(N_BANKS)) u_wr_en (
    .valid_i(wr_beat),
    .grp_i  (wr_grp_d),
    .log2x_i(log2x),
    .en_o   (wr_en_d)
  );

  bgm_en_decode #(.N_BANKS(N_BANKS)) u_rd_en (
    .valid_i(rd_beat),
    .grp_i  (rd_grp_d),
    .log2x_i(log2x),
    .en_o   (rd_en_d)
  );

  bgm_wr_route #(.N_BANKS(N_BANKS), .ROW_W(ROW_W)) u_route (
    .data_i (wr_data_i),
    .log2x_i(log2x),
    .bank_o (wr_data_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q   <= '0;
      wr_row_q  <= '0;
      wr_grp_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= wr_en_d;
      if (wr_beat) begin
        wr_row_q  <= wr_row_d;
        wr_grp_q  <= wr_grp_d;
        wr_data_q <= wr_data_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_q   <= '0;
      rd_row_q  <= '0;
      rd_grp_q  <= '0;
      rd_lx_q   <= '0;
      rd_dv_q   <= 1'b0;
      sel_grp_q <= '0;
      sel_lx_q  <= '0;
    end else begin
      rd_en_q <= rd_en_d;
      rd_dv_q <= |rd_en_q;
      if (rd_beat) begin
        rd_row_q <= rd_row_d;
        rd_grp_q <= rd_grp_d;
        rd_lx_q  <= log2x;
      end
      // banks answer one cycle after the enable
      if (|rd_en_q) begin
        sel_grp_q <= rd_grp_q;
        sel_lx_q  <= rd_lx_q;
      end
    end
  end

  bgm_rd_gather #(.N_BANKS(N_BANKS), .ROW_W(ROW_W)) u_gather (
    .bank_i (rd_bank_data_i),
    .grp_i  (sel_grp_q),
    .log2x_i(sel_lx_q),
    .data_o (rd_data_o)
  );

  assign wr_en_o         = wr_en_q;
  assign wr_row_o        = wr_row_q;
  assign wr_grp_o        = wr_grp_q;
  assign wr_data_o       = wr_data_q;
  assign rd_en_o         = rd_en_q;
  assign rd_row_o        = rd_row_q;
  assign rd_grp_o        = rd_grp_q;
  assign rd_data_valid_o = rd_dv_q;
  assign cfg_err_o       = cfg_err;

  // R2
  wr_grp_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o != '0) |-> ($countones(wr_en_o) == (1 << $past(log2x))));

  // R9
  rd_grp_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o != '0) |-> ($countones(rd_en_o) == (1 << $past(log2x))));

  // R7
  err_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && wr_valid_i) |=> (wr_en_o == '0));

  // R6
  tile_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tile_start_i && wr_valid_i && !cfg_err_o) |=> (wr_en_o[0] && wr_row_o == '0));

  // R10
  rd_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_valid_o |-> $past(rd_en_o != '0));
endmodule

// File: tb/bank_group_mapper_tb.sv
`timescale 1ns/1ps
module bank_group_mapper_tb;
  localparam int NB = 8;
  localparam int RW = 16;
  localparam int RA = 4;
  localparam int WW = NB * RW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tile = 1'b0;
  logic [1:0]    wsel = 2'd0;
  logic          wr_valid = 1'b0;
  logic [WW-1:0] wr_data = '0;
  logic          rd_valid = 1'b0;
  logic [WW-1:0] bank_data;
  logic [NB-1:0] wr_en, rd_en;
  logic [RA-1:0] wr_row, rd_row;
  logic [2:0]    wr_grp, rd_grp;
  logic [WW-1:0] wr_data_out, rd_data;
  logic          rd_dv, cfg_err;

  // second instance with four banks, only for the group-count limit
  logic [1:0]    s_wsel = 2'd1;
  logic [3:0]    s_wr_en, s_rd_en;
  logic [RA-1:0] s_wr_row, s_rd_row;
  logic [1:0]    s_wr_grp, s_rd_grp;
  logic [4*RW-1:0] s_wr_data, s_rd_data;
  logic          s_dv, s_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  for (genvar b = 0; b < NB; b++) begin : g_bd
    assign bank_data[b*RW +: RW] = 16'hB000 + 16'(b);
  end

  bank_group_mapper #(.N_BANKS(NB), .ROW_W(RW), .ROW_AW(RA)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tile_start_i(tile), .width_sel_i(wsel),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .rd_valid_i(rd_valid),
    .rd_bank_data_i(bank_data), .wr_en_o(wr_en), .wr_row_o(wr_row),
    .wr_grp_o(wr_grp), .wr_data_o(wr_data_out), .rd_en_o(rd_en),
    .rd_row_o(rd_row), .rd_grp_o(rd_grp), .rd_data_o(rd_data),
    .rd_data_valid_o(rd_dv), .cfg_err_o(cfg_err)
  );

  bank_group_mapper #(.N_BANKS(4), .ROW_W(RW), .ROW_AW(RA)) u_small (
    .clk_i(clk), .rst_ni(rst_n), .tile_start_i(1'b0), .width_sel_i(s_wsel),
    .wr_valid_i(1'b0), .wr_data_i('0), .rd_valid_i(1'b0),
    .rd_bank_data_i(bank_data[4*RW-1:0]), .wr_en_o(s_wr_en), .wr_row_o(s_wr_row),
    .wr_grp_o(s_wr_grp), .wr_data_o(s_wr_data), .rd_en_o(s_rd_en),
    .rd_row_o(s_rd_row), .rd_grp_o(s_rd_grp), .rd_data_o(s_rd_data),
    .rd_data_valid_o(s_dv), .cfg_err_o(s_err)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [WW-1:0] mkdata(input int idx);
    logic [WW-1:0] d;
    for (int s = 0; s < NB; s++) d[s*RW +: RW] = {8'(idx), 8'(s)};
    return d;
  endfunction

  // {tile, width code, valid, expected enables, expected row}
  localparam logic [15:0] VEC [22] = '{
    {1'b1, 2'd0, 1'b1, 8'h01, 4'd0},
    {1'b0, 2'd0, 1'b1, 8'h02, 4'd0},
    {1'b0, 2'd0, 1'b0, 8'h00, 4'd0},
    {1'b0, 2'd0, 1'b1, 8'h04, 4'd0},
    {1'b0, 2'd0, 1'b1, 8'h08, 4'd0},
    {1'b0, 2'd0, 1'b1, 8'h10, 4'd0},
    {1'b0, 2'd0, 1'b1, 8'h20, 4'd0},
    {1'b0, 2'd0, 1'b1, 8'h40, 4'd0},
    {1'b0, 2'd0, 1'b1, 8'h80, 4'd0},
    {1'b0, 2'd0, 1'b1, 8'h01, 4'd1},
    {1'b1, 2'd1, 1'b1, 8'h03, 4'd0},
    {1'b0, 2'd1, 1'b1, 8'h0C, 4'd0},
    {1'b0, 2'd1, 1'b1, 8'h30, 4'd0},
    {1'b0, 2'd1, 1'b1, 8'hC0, 4'd0},
    {1'b0, 2'd1, 1'b1, 8'h03, 4'd1},
    {1'b0, 2'd3, 1'b1, 8'h00, 4'd0},
    {1'b0, 2'd1, 1'b1, 8'h0C, 4'd1},
    {1'b1, 2'd2, 1'b1, 8'h0F, 4'd0},
    {1'b0, 2'd2, 1'b1, 8'hF0, 4'd0},
    {1'b0, 2'd2, 1'b1, 8'h0F, 4'd1},
    {1'b1, 2'd2, 1'b0, 8'h00, 4'd0},
    {1'b0, 2'd2, 1'b1, 8'h0F, 4'd0}
  };

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    #12;
    chk("R1 wr_en", 64'(wr_en), 64'h0);
    chk("R1 rd_en", 64'(rd_en), 64'h0);
    chk("R1 rd_dv", 64'(rd_dv), 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < 22; i++) begin
      logic [7:0] een;
      logic [3:0] erow;
      int x;
      @(negedge clk);
      {tile, wsel, wr_valid, een, erow} = VEC[i];
      wr_data = mkdata(i);
      x = 1 << wsel;
      @(posedge clk); #1;
      chk($sformatf("R4 enables vec %0d", i), 64'(wr_en), 64'(een));
      if (wsel == 2'd3) chk("R7 err flag", 64'(cfg_err), 64'h1);
      if (een != 8'h00) begin
        int fb = 0;
        for (int b = NB - 1; b >= 0; b--) if (een[b]) fb = b;
        chk($sformatf("R4 row vec %0d", i), 64'(wr_row), 64'(erow));
        chk($sformatf("R2 grp vec %0d", i), 64'(wr_grp), 64'(fb / x));
        for (int b = 0; b < NB; b++)
          chk($sformatf("R3 slice bank %0d vec %0d", b, i),
              64'(wr_data_out[b*RW +: RW]), 64'({8'(i), 8'(b % x)}));
      end
    end

    // R8 row wrap with four-bank groups
    for (int k = 0; k <= 32; k++) begin
      @(negedge clk);
      tile = (k == 0); wsel = 2'd2; wr_valid = 1'b1; wr_data = mkdata(k);
      @(posedge clk); #1;
      if (k == 31) begin
        chk("R8 last en", 64'(wr_en), 64'hF0);
        chk("R8 last row", 64'(wr_row), 64'd15);
      end
      if (k == 32) begin
        chk("R8 wrap en", 64'(wr_en), 64'h0F);
        chk("R8 wrap row", 64'(wr_row), 64'd0);
      end
    end

    // R6 R9 R10: rewind with write and read beats in the same cycle
    @(negedge clk);
    tile = 1'b1; wsel = 2'd1; wr_valid = 1'b1; rd_valid = 1'b1;
    @(posedge clk); #1;
    chk("R6 wr origin", 64'(wr_en), 64'h03);
    chk("R6 rd origin", 64'(rd_en), 64'h03);
    chk("R9 rd row", 64'(rd_row), 64'd0);
    @(negedge clk);
    tile = 1'b0; wr_valid = 1'b0; rd_valid = 1'b1;
    @(posedge clk); #1;
    chk("R9 rd next grp", 64'(rd_en), 64'h0C);
    chk("R9 rd grp idx", 64'(rd_grp), 64'd1);
    chk("R5 no write", 64'(wr_en), 64'h00);
    chk("R10 dv", 64'(rd_dv), 64'h1);
    chk("R10 slice0", 64'(rd_data[0 +: RW]), 64'hB000);
    chk("R10 slice1", 64'(rd_data[RW +: RW]), 64'hB001);
    chk("R10 upper zero", 64'(rd_data[WW-1:2*RW] != '0), 64'h0);
    @(negedge clk);
    rd_valid = 1'b0; wr_valid = 1'b1;
    @(posedge clk); #1;
    chk("R9 write unmoved by reads", 64'(wr_en), 64'h0C);
    chk("R9 rd idle", 64'(rd_en), 64'h00);
    chk("R10 slice0 grp1", 64'(rd_data[0 +: RW]), 64'hB002);
    chk("R10 slice1 grp1", 64'(rd_data[RW +: RW]), 64'hB003);
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b1;
    @(posedge clk); #1;
    chk("R9 read unmoved by writes", 64'(rd_en), 64'h30);

    // R7 read beat under error, then group-count limit
    @(negedge clk);
    wsel = 2'd3; rd_valid = 1'b1;
    @(posedge clk); #1;
    chk("R7 rd dropped", 64'(rd_en), 64'h00);
    @(negedge clk);
    wsel = 2'd1; rd_valid = 1'b1;
    @(posedge clk); #1;
    chk("R7 rd pos held", 64'(rd_en), 64'hC0);
    @(negedge clk);
    rd_valid = 1'b0; wsel = 2'd2; s_wsel = 2'd2;
    #1;
    chk("R7 four banks x4", 64'(s_err), 64'h1);
    chk("R7 eight banks x4", 64'(cfg_err), 64'h0);
    s_wsel = 2'd1;
    #1;
    chk("R7 four banks x2", 64'(s_err), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule